// File: doc/BRIEF.md
# Instruction Cache Coordinate Resolver

This block is the tag directory of a small instruction cache. It keeps the virtual base address and address-space identifier of every cache line, so the rest of the pipeline can carry a 12-bit cache coordinate instead of a full virtual address. A coordinate is a line number in bits [11:6] and a halfword position inside the 128-byte line in bits [5:0]. The block converts in both directions. Forward lookup searches all valid lines for a virtual address and returns its coordinate. Reverse resolve rebuilds the virtual address from a coordinate, for example when a saved exception PC is read by software.

A line refill engine installs or invalidates entries through a plain fill port. The fill port refuses any line that the reference-tracking logic marks as pinned in `pin_i`, because that line still holds an instruction in flight. Lookup and resolve are valid/ready streams with one register stage each. A request is accepted on a clock edge where `*_valid` and `*_ready` are both high. `*_ready` is high whenever the result register is empty or its consumer takes the result in that same cycle. A result stays unchanged while `*_out_valid` is high and `*_out_ready` is low.

Top module: `coord_resolver`

## Requirements
- R1: After reset no line is valid, `lk_out_valid`, `rs_out_valid`, `fill_ack` and `fill_busy` are 0, and both request readies are 1.
- R2: A fill request (`fill_req`=1, `fill_inval`=0) to an unpinned line stores `fill_va[VA_W-1:7]` and `fill_asid`, marks the line valid, and pulses `fill_ack` for one cycle on the following cycle.
- R3: A fill or invalidate request to a line whose `pin_i` bit is 1 pulses `fill_busy` (not `fill_ack`) on the following cycle and leaves that line's entry unchanged.
- R4: An invalidate request (`fill_req`=1, `fill_inval`=1) to an unpinned line clears its valid bit and pulses `fill_ack`; later lookups no longer hit it.
- R5: A lookup hits when a valid line holds tag `lk_va[VA_W-1:7]` and ASID `lk_asid`. It returns `lk_hit`=1 and `lk_coord` = {line, `lk_va[6:1]`}; `lk_va[0]` has no effect.
- R6: A lookup with no matching valid line returns `lk_hit`=0 and `lk_coord`=0; a line whose tag matches but whose ASID differs is a miss.
- R7: When several valid lines match, the lowest line number is returned.
- R8: Resolving a coordinate whose line is valid returns `rs_va` = {stored tag, `rs_coord[5:0]`, 1'b0} with `rs_err`=0.
- R9: Resolving a coordinate whose line is invalid returns `rs_err`=1 and `rs_va`=0.
- R10: Each stream returns exactly one result per accepted request, in request order, one cycle after acceptance. `*_ready` equals `!*_out_valid || *_out_ready`. A pending result holds stable while its consumer stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | LINES | Per-line pinned flag from reference tracking |
| fill_req | input | 1 | Fill or invalidate request |
| fill_inval | input | 1 | 1: invalidate the line, 0: install the line |
| fill_line | input | 6 | Target line number |
| fill_va | input | VA_W | Line base virtual address (bits [6:0] ignored) |
| fill_asid | input | ASID_W | Address-space identifier stored with the line |
| fill_ack | output | 1 | Previous-cycle request was applied |
| fill_busy | output | 1 | Previous-cycle request was refused (pinned) |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_va | input | VA_W | Virtual address to look up |
| lk_asid | input | ASID_W | ASID to match |
| lk_out_valid | output | 1 | Lookup result valid |
| lk_out_ready | input | 1 | Consumer takes the lookup result |
| lk_hit | output | 1 | Lookup hit |
| lk_coord | output | 12 | Coordinate {line, halfword offset} |
| rs_valid | input | 1 | Resolve request valid |
| rs_ready | output | 1 | Resolve request can be accepted |
| rs_coord | input | 12 | Coordinate to resolve |
| rs_out_valid | output | 1 | Resolve result valid |
| rs_out_ready | input | 1 | Consumer takes the resolve result |
| rs_va | output | VA_W | Rebuilt virtual address |
| rs_err | output | 1 | Coordinate named an invalid line |

## Verification
Every cycle, the assertions check four things. A fill to a pinned line is answered with busy and any other fill with an acknowledge. A stalled lookup or resolve result stays stable. An error result always carries a zero address. The bench scenarios cover the rest. They show that tags, ASIDs and offsets land in the right coordinate or address fields, that refused fills and invalidates really leave the directory as it was, and that the lowest line wins among duplicates. They also show that results come out complete and in order while the output ready toggles.

// File: rtl/coord_resolver_pkg.sv
package coord_resolver_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_DONE = 2'd1,
    FILL_REFUSED = 2'd2
  } fill_resp_e;
endpackage

// File: rtl/coord_tag_store.sv
module coord_tag_store #(
  parameter int LINES  = 64,
  parameter int TAG_W  = 32,
  parameter int ASID_W = 8,
  localparam int LN_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  pin_i,
  input  logic              fill_req,
  input  logic              fill_inval,
  input  logic [LN_W-1:0]   fill_line,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [ASID_W-1:0] fill_asid,
  output logic              fill_ack,
  output logic              fill_busy,
  output logic [LINES-1:0]  vld_o,
  output logic [TAG_W-1:0]  tag_o  [LINES],
  output logic [ASID_W-1:0] asid_o [LINES]
);
  import coord_resolver_pkg::*;

  fill_resp_e resp_q;
  logic       refused;
  logic       accepted;

  assign refused  = fill_req && pin_i[fill_line];
  assign accepted = fill_req && !pin_i[fill_line];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic wr;
    assign wr = accepted && (fill_line == LN_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_o[g]  <= 1'b0;
        tag_o[g]  <= '0;
        asid_o[g] <= '0;
      end else if (wr) begin
        vld_o[g] <= !fill_inval;
        if (!fill_inval) begin
          tag_o[g]  <= fill_tag;
          asid_o[g] <= fill_asid;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        resp_q <= FILL_IDLE;
    else if (refused)  resp_q <= FILL_REFUSED;
    else if (accepted) resp_q <= FILL_DONE;
    else               resp_q <= FILL_IDLE;
  end

  assign fill_ack  = (resp_q == FILL_DONE);
  assign fill_busy = (resp_q == FILL_REFUSED);

  assert_pinned_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && pin_i[fill_line]) |=> (fill_busy && !fill_ack));
  assert_free_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !pin_i[fill_line]) |=> (fill_ack && !fill_busy));
endmodule

// File: rtl/coord_fwd_lookup.sv
module coord_fwd_lookup #(
  parameter int LINES  = 64,
  parameter int TAG_W  = 32,
  parameter int ASID_W = 8,
  parameter int VA_W   = 39,
  parameter int LB_W   = 7,
  localparam int LN_W  = $clog2(LINES),
  localparam int CO_W  = LN_W + LB_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  vld_i,
  input  logic [TAG_W-1:0]  tag_i  [LINES],
  input  logic [ASID_W-1:0] asid_i [LINES],
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VA_W-1:0]   in_va,
  input  logic [ASID_W-1:0] in_asid,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [CO_W-1:0]   out_coord
);
  logic [LINES-1:0] match;
  logic             hit_c;
  logic [LN_W-1:0]  line_c;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = vld_i[g] && (tag_i[g] == in_va[VA_W-1:LB_W]) &&
                      (asid_i[g] == in_asid);
  end

  // Scan downward so the lowest matching line is the last one kept.
  always_comb begin
    hit_c  = 1'b0;
    line_c = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_c  = 1'b1;
        line_c = LN_W'(i);
      end
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_coord <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit   <= hit_c;
        out_coord <= hit_c ? {line_c, in_va[LB_W-1:1]} : '0;
      end
    end
  end

  assert_lk_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_coord) && $stable(out_hit)));
  assert_lk_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_coord == '0));
endmodule

// File: rtl/coord_rev_resolve.sv
module coord_rev_resolve #(
  parameter int LINES = 64,
  parameter int TAG_W = 32,
  parameter int VA_W  = 39,
  parameter int LB_W  = 7,
  localparam int LN_W = $clog2(LINES),
  localparam int CO_W = LN_W + LB_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] vld_i,
  input  logic [TAG_W-1:0] tag_i [LINES],
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CO_W-1:0]  in_coord,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VA_W-1:0]  out_va,
  output logic             out_err
);
  logic [LN_W-1:0] line;
  logic            line_ok;

  assign line     = in_coord[CO_W-1:LB_W-1];
  assign line_ok  = vld_i[line];
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_va    <= '0;
      out_err   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_err <= !line_ok;
        out_va  <= line_ok ? {tag_i[line], in_coord[LB_W-2:0], 1'b0} : '0;
      end
    end
  end

  assert_rs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_va) && $stable(out_err)));
  assert_rs_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_va == '0));
endmodule

// File: rtl/coord_resolver.sv
module coord_resolver #(
  parameter int VA_W       = 39,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 128,
  parameter int ASID_W     = 8,
  localparam int LB_W      = $clog2(LINE_BYTES),
  localparam int LN_W      = $clog2(LINES),
  localparam int TAG_W     = VA_W - LB_W,
  localparam int CO_W      = LN_W + LB_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  pin_i,
  input  logic              fill_req,
  input  logic              fill_inval,
  input  logic [LN_W-1:0]   fill_line,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [ASID_W-1:0] fill_asid,
  output logic              fill_ack,
  output logic              fill_busy,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_out_valid,
  input  logic              lk_out_ready,
  output logic              lk_hit,
  output logic [CO_W-1:0]   lk_coord,
  input  logic              rs_valid,
  output logic              rs_ready,
  input  logic [CO_W-1:0]   rs_coord,
  output logic              rs_out_valid,
  input  logic              rs_out_ready,
  output logic [VA_W-1:0]   rs_va,
  output logic              rs_err
);
  logic [LINES-1:0]  vld;
  logic [TAG_W-1:0]  tags  [LINES];
  logic [ASID_W-1:0] asids [LINES];

  coord_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .ASID_W(ASID_W)) u_store (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .fill_req(fill_req), .fill_inval(fill_inval), .fill_line(fill_line),
    .fill_tag(fill_va[VA_W-1:LB_W]), .fill_asid(fill_asid),
    .fill_ack(fill_ack), .fill_busy(fill_busy),
    .vld_o(vld), .tag_o(tags), .asid_o(asids)
  );

  coord_fwd_lookup #(.LINES(LINES), .TAG_W(TAG_W), .ASID_W(ASID_W),
                     .VA_W(VA_W), .LB_W(LB_W)) u_fwd (
    .clk(clk), .rst_n(rst_n), .vld_i(vld), .tag_i(tags), .asid_i(asids),
    .in_valid(lk_valid), .in_ready(lk_ready), .in_va(lk_va), .in_asid(lk_asid),
    .out_valid(lk_out_valid), .out_ready(lk_out_ready),
    .out_hit(lk_hit), .out_coord(lk_coord)
  );

  coord_rev_resolve #(.LINES(LINES), .TAG_W(TAG_W), .VA_W(VA_W), .LB_W(LB_W)) u_rev (
    .clk(clk), .rst_n(rst_n), .vld_i(vld), .tag_i(tags),
    .in_valid(rs_valid), .in_ready(rs_ready), .in_coord(rs_coord),
    .out_valid(rs_out_valid), .out_ready(rs_out_ready),
    .out_va(rs_va), .out_err(rs_err)
  );
endmodule

// File: tb/coord_resolver_test.sv
module coord_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 39;
  localparam int ASID_W = 8;
  localparam int LINES = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LINES-1:0] pin_i = '0;
  logic fill_req = 0, fill_inval = 0;
  logic [5:0] fill_line = '0;
  logic [VA_W-1:0] fill_va = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic fill_ack, fill_busy;
  logic lk_valid = 0, lk_ready, lk_out_valid, lk_out_ready = 1, lk_hit;
  logic [VA_W-1:0] lk_va = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic [11:0] lk_coord;
  logic rs_valid = 0, rs_ready, rs_out_valid, rs_out_ready = 1, rs_err;
  logic [11:0] rs_coord = '0;
  logic [VA_W-1:0] rs_va;

  int checks = 0, errors = 0;
  bit stall = 0;
  logic [31:0] mtag [LINES];
  logic [ASID_W-1:0] masid [LINES];
  logic [LINES-1:0] mvld = '0;
  logic [12:0] lk_q [$];
  logic [VA_W:0] rs_q [$];
  string lk_rq [$];
  string rs_rq [$];

  coord_resolver uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Output ready patterns change on the falling edge.
  always @(negedge clk) begin
    lk_out_ready <= stall ? ~lk_out_ready : 1'b1;
    rs_out_ready <= stall ? ~rs_out_ready : 1'b1;
  end

  // Monitor: a transfer happens at the next rising edge when valid && ready.
  always begin
    @(negedge clk); #3;
    if (rst_n && lk_out_valid && lk_out_ready) begin
      if (lk_q.size() == 0) check("R10 unexpected lookup", 1, 0);
      else check(lk_rq.pop_front(), 64'({lk_hit, lk_coord}), 64'(lk_q.pop_front()));
    end
    if (rst_n && rs_out_valid && rs_out_ready) begin
      if (rs_q.size() == 0) check("R10 unexpected resolve", 1, 0);
      else check(rs_rq.pop_front(), 64'({rs_err, rs_va}), 64'(rs_q.pop_front()));
    end
  end

  task automatic fill(bit inval, int line, logic [VA_W-1:0] va, logic [7:0] asid, string req);
    bit pinned;
    @(negedge clk); #1;
    fill_req = 1; fill_inval = inval; fill_line = 6'(line); fill_va = va; fill_asid = asid;
    pinned = pin_i[line];
    @(negedge clk); #1;
    fill_req = 0;
    check(req, {fill_ack, fill_busy}, pinned ? 2'b01 : 2'b10);
    if (!pinned) begin
      mvld[line] = !inval;
      if (!inval) begin mtag[line] = va[VA_W-1:7]; masid[line] = asid; end
    end
  endtask

  task automatic lookup(logic [VA_W-1:0] va, logic [7:0] asid, string req);
    logic [12:0] exp = '0;
    bit fire;
    for (int i = LINES - 1; i >= 0; i--)
      if (mvld[i] && mtag[i] == va[VA_W-1:7] && masid[i] == asid)
        exp = {1'b1, 6'(i), va[6:1]};
    lk_q.push_back(exp); lk_rq.push_back(req);
    @(negedge clk); #1;
    lk_valid = 1; lk_va = va; lk_asid = asid;
    forever begin
      #1 fire = lk_ready;
      @(negedge clk); #1;
      if (fire) break;
    end
    lk_valid = 0;
  endtask

  task automatic resolve(logic [11:0] co, string req);
    logic [VA_W:0] exp;
    bit fire;
    exp = mvld[co[11:6]] ? {1'b0, mtag[co[11:6]], co[5:0], 1'b0} : {1'b1, {VA_W{1'b0}}};
    rs_q.push_back(exp); rs_rq.push_back(req);
    @(negedge clk); #1;
    rs_valid = 1; rs_coord = co;
    forever begin
      #1 fire = rs_ready;
      @(negedge clk); #1;
      if (fire) break;
    end
    rs_valid = 0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    check("R1 reset idle", {lk_out_valid, rs_out_valid, fill_ack, fill_busy, lk_ready, rs_ready}, 6'b000011);
    resolve(12'h000, "R1 no valid line after reset");
    lookup(39'h0, 8'h0, "R1 reset lookup misses");

    fill(0, 0,  39'h12_3456_7880, 8'h01, "R2 fill line 0 ack");
    fill(0, 5,  39'h7F_FFFF_FF80, 8'h02, "R2 fill line 5 ack");
    fill(0, 63, 39'h00_0000_0100, 8'h03, "R2 fill line 63 ack");
    lookup(39'h12_3456_78A5, 8'h01, "R5 hit line 0, bit0 ignored");
    lookup(39'h7F_FFFF_FFFE, 8'h02, "R5 hit line 5 top offset");
    lookup(39'h00_0000_0100, 8'h03, "R5 hit line 63 offset 0");
    lookup(39'h12_3456_7880, 8'h02, "R6 asid mismatch misses");
    lookup(39'h12_3456_7900, 8'h01, "R6 tag mismatch misses");
    resolve({6'd5, 6'h3F}, "R8 resolve line 5");
    resolve({6'd0, 6'h12}, "R8 resolve line 0");
    resolve({6'd63, 6'h01}, "R8 resolve line 63");
    resolve({6'd7, 6'h05}, "R9 invalid line error");

    pin_i[5] = 1;
    fill(0, 5, 39'h01_0000_0000, 8'h09, "R3 pinned fill refused");
    resolve({6'd5, 6'h00}, "R3 pinned line unchanged");
    fill(1, 5, 39'h0, 8'h0, "R3 pinned invalidate refused");
    lookup(39'h7F_FFFF_FF80, 8'h02, "R3 pinned line still hits");
    pin_i[5] = 0;

    fill(1, 63, 39'h0, 8'h0, "R4 invalidate ack");
    lookup(39'h00_0000_0100, 8'h03, "R4 invalidated line misses");
    resolve({6'd63, 6'h00}, "R4 invalidated line errors");

    fill(0, 10, 39'h55_5555_5500, 8'h07, "R2 fill line 10");
    fill(0, 3,  39'h55_5555_5500, 8'h07, "R2 fill line 3");
    lookup(39'h55_5555_5542, 8'h07, "R7 lowest matching line");

    stall = 1;
    for (int k = 0; k < 6; k++) begin
      lookup(39'h12_3456_7880 + 39'(k * 6), 8'h01, "R10 lookup under stall");
      resolve({6'd3, 6'(k * 9)}, "R10 resolve under stall");
    end
    stall = 0;
    repeat (6) @(negedge clk);
    check("R10 all lookups returned", lk_q.size(), 0);
    check("R10 all resolves returned", rs_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule